// File: doc/BRIEF.md
# Power-On Strap Latch Controller

This block lets four pads do two jobs. While the chip comes out of power-on reset, the four pads are inputs. Their levels are read once and kept in a 4-bit configuration word. After that, the pads switch to outputs and carry four internal clock signals. Board resistors set the levels that are read; a pad left without a resistor reads high.

The configuration word is split into two decoded results. The first is a 3-bit CPU frequency index, exported as a code rather than a clock. The second is a flag that says whether the bus clock runs synchronously at half the CPU rate or from a fixed 32 MHz source. One frequency index, 011, always forces the fixed bus source.

Sampling happens on the first clock edge where the reset-done input is seen high. A valid flag rises one cycle later and releases the pad drivers. The word stays frozen until the synchronous reset is asserted again.

Top module: `strap_pad_ctrl`

## Requirements
- R1: While `cfg_valid` is low, `pad_oe` is 4'b0000 and `pad_out` is 4'b0000.
- R2: After a reset cycle, `cfg_word` is 4'b1111 (all straps read as pulled up) and `cfg_valid` is 0.
- R3: On the first rising edge after reset at which `por_done` is high, `cfg_word` loads `pad_in`. Bit 0 is the bus-mode strap. Bits 1, 2 and 3 are frequency select bits 0, 1 and 2.
- R4: Once captured, `cfg_word` ignores later `pad_in` changes and later `por_done` pulses until `rst` is asserted.
- R5: `cfg_valid` goes high on the edge after the capture edge and stays high until `rst`.
- R6: `cpu_sel` equals {cfg_word[3], cfg_word[2], cfg_word[1]}. Its values map to 000=50, 001=60, 010=66.8, 011=75.9, 100=55, 101=75.9, 110=83.3 and 111=68.5 MHz.
- R7: For any `cpu_sel` other than 3'b011, `bus_sync` equals `cfg_word[0]`. A value of 1 means half the CPU rate; 0 means the fixed 32 MHz rate.
- R8: When `cpu_sel` is 3'b011, `bus_sync` is 0 whatever the value of `cfg_word[0]`.
- R9: While `cfg_valid` is high, `pad_oe` is 4'b1111 and `pad_out` follows `clk_src` combinationally.
- R10: Asserting `rst` after a capture clears the state, so a later `por_done` captures a new word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| por_done | input | 1 | Power-on reset finished |
| pad_in | input | 4 | Levels read from the shared pads |
| clk_src | input | 4 | Internal clocks to drive onto the pads |
| pad_oe | output | 4 | Per-pad output enable |
| pad_out | output | 4 | Per-pad output data |
| cfg_word | output | 4 | Latched strap word |
| cfg_valid | output | 1 | Strap word captured and pads released |
| cpu_sel | output | 3 | CPU frequency index |
| bus_sync | output | 1 | 1 = bus at half CPU rate, 0 = fixed 32 MHz |

## Verification
`cfg_word`, `cpu_sel` and `bus_sync` are due one rising edge after `por_done` is first seen high. `cfg_valid`, `pad_oe` and the pad data follow one edge later. `pad_out` tracks `clk_src` with no register in the path.

The bench drives inputs on the falling edge and samples just before the next rising edge. It checks the decoded fields after the capture edge. It checks that the pads are still disabled at that point, and that they are enabled only after the following edge. Each result is compared in exactly the cycle it is due.

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl #(
  parameter int NPAD = 4,
  parameter logic [NPAD-1:0] PULL_VAL = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            por_done,
  input  logic [NPAD-1:0] pad_in,
  input  logic [NPAD-1:0] clk_src,
  output logic [NPAD-1:0] pad_oe,
  output logic [NPAD-1:0] pad_out,
  output logic [NPAD-1:0] cfg_word,
  output logic            cfg_valid,
  output logic [2:0]      cpu_sel,
  output logic            bus_sync
);

  localparam int MODE_BIT = 0;
  localparam logic [2:0] FIXED_BUS_CODE = 3'b011;

  logic taken;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word  <= PULL_VAL;
      taken     <= 1'b0;
      cfg_valid <= 1'b0;
    end else begin
      if (por_done && !taken) begin
        cfg_word <= pad_in;
        taken    <= 1'b1;
      end
      cfg_valid <= taken;
    end
  end

  assign cpu_sel  = cfg_word[3:1];
  assign bus_sync = cfg_word[MODE_BIT] && (cpu_sel != FIXED_BUS_CODE);

  for (genvar p = 0; p < NPAD; p++) begin : g_pad
    assign pad_oe[p]  = cfg_valid;
    assign pad_out[p] = cfg_valid & clk_src[p];
  end

endmodule

// File: rtl/strap_pad_ctrl_chk.sv
module strap_pad_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       por_done,
  input logic [3:0] pad_in,
  input logic [3:0] clk_src,
  input logic [3:0] pad_oe,
  input logic [3:0] pad_out,
  input logic [3:0] cfg_word,
  input logic       cfg_valid,
  input logic [2:0] cpu_sel,
  input logic       bus_sync
);

  logic got;
  always_ff @(posedge clk) begin
    if (rst) got <= 1'b0;
    else if (por_done) got <= 1'b1;
  end

  a_r1_pads_off: assert property (@(posedge clk) disable iff (rst)
    !cfg_valid |-> (pad_oe == 4'b0000 && pad_out == 4'b0000));

  a_r2_reset_state: assert property (@(posedge clk)
    rst |=> (cfg_word == 4'b1111 && !cfg_valid));

  a_r3_capture: assert property (@(posedge clk) disable iff (rst)
    (por_done && !got) |=> cfg_word == $past(pad_in));

  a_r4_frozen: assert property (@(posedge clk) disable iff (rst)
    got |=> $stable(cfg_word));

  a_r5_valid_sticky: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |=> cfg_valid);

  a_r5_valid_after_capture: assert property (@(posedge clk) disable iff (rst)
    (por_done && !got) |=> !cfg_valid ##1 cfg_valid);

  a_r8_fixed_bus: assert property (@(posedge clk) disable iff (rst)
    (cpu_sel == 3'b011) |-> !bus_sync);

  a_r9_pads_drive: assert property (@(posedge clk) disable iff (rst)
    cfg_valid |-> (pad_oe == 4'b1111 && pad_out == clk_src));

endmodule

bind strap_pad_ctrl strap_pad_ctrl_chk i_chk (
  .clk(clk), .rst(rst), .por_done(por_done), .pad_in(pad_in),
  .clk_src(clk_src), .pad_oe(pad_oe), .pad_out(pad_out),
  .cfg_word(cfg_word), .cfg_valid(cfg_valid), .cpu_sel(cpu_sel),
  .bus_sync(bus_sync)
);

// File: tb/test_strap_pad_ctrl.sv
module test_strap_pad_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       por_done = 1'b0;
  logic [3:0] pad_in = 4'b0000;
  logic [3:0] clk_src = 4'b0000;
  logic [3:0] pad_oe, pad_out, cfg_word;
  logic       cfg_valid, bus_sync;
  logic [2:0] cpu_sel;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  strap_pad_ctrl i_strap_pad_ctrl (
    .clk(clk), .rst(rst), .por_done(por_done), .pad_in(pad_in),
    .clk_src(clk_src), .pad_oe(pad_oe), .pad_out(pad_out),
    .cfg_word(cfg_word), .cfg_valid(cfg_valid), .cpu_sel(cpu_sel),
    .bus_sync(bus_sync)
  );

  function automatic logic [2:0] exp_cpu(input logic [3:0] w);
    return {w[3], w[2], w[1]};
  endfunction

  function automatic logic exp_bus(input logic [3:0] w);
    if ({w[3], w[2], w[1]} == 3'b011) return 1'b0;
    return w[0];
  endfunction

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    #2;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    por_done = 1'b0;
    step();
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic run_case(input logic [3:0] strap, input int wait_cyc);
    logic [3:0] junk;
    do_reset();
    pad_in = strap;
    for (int i = 0; i < wait_cyc; i++) begin
      step();
      chk("R2 word before capture", cfg_word, 4'b1111);
      chk("R1 oe before capture", pad_oe, 4'b0000);
    end
    @(negedge clk);
    por_done = 1'b1;
    step();
    por_done = 1'b0;
    chk("R3 captured word", cfg_word, strap);
    chk("R5 valid not yet", {3'b000, cfg_valid}, 4'b0000);
    clk_src = 4'($urandom);
    #1;
    chk("R1 pad_out still off", pad_out, 4'b0000);
    chk("R6 cpu_sel", {1'b0, cpu_sel}, {1'b0, exp_cpu(strap)});
    if (exp_cpu(strap) == 3'b011)
      chk("R8 fixed bus on code 011", {3'b000, bus_sync}, {3'b000, exp_bus(strap)});
    else
      chk("R7 bus mode", {3'b000, bus_sync}, {3'b000, exp_bus(strap)});
    junk = ~strap;
    pad_in = junk;
    step();
    chk("R5 valid rises", {3'b000, cfg_valid}, 4'b0001);
    chk("R9 oe on", pad_oe, 4'b1111);
    for (int k = 0; k < 3; k++) begin
      clk_src = 4'($urandom);
      #1;
      chk("R9 pad follows clock", pad_out, clk_src);
    end
    @(negedge clk);
    por_done = 1'b1;
    pad_in = 4'($urandom);
    step();
    por_done = 1'b0;
    step();
    chk("R4 word frozen", cfg_word, strap);
    chk("R5 valid held", {3'b000, cfg_valid}, 4'b0001);
  endtask

  initial begin
    fork
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    join_none
    void'($urandom(32'd12345));
    step();
    step();
    chk("R2 reset word", cfg_word, 4'b1111);
    chk("R2 reset valid", {3'b000, cfg_valid}, 4'b0000);
    chk("R1 reset oe", pad_oe, 4'b0000);
    for (int c = 0; c < 16; c++) run_case(4'(c), c % 3);
    // R10: re-reset after a capture allows a new word
    run_case(4'b0110, 0);
    run_case(4'b0111, 2);
    for (int r = 0; r < 60; r++) run_case(4'($urandom), int'($urandom % 5));
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule